// File: doc/BRIEF.md
# USB Device Interrupt Collector with Frame-Start Watchdog

This block gathers the interrupt events of a USB device-side controller into one status register and drives a single level interrupt line. The packet engine reports its events as one-cycle strobes: bus reset detected, start-of-frame or end-of-packet seen, and per-endpoint completions for endpoints 1 to 7. Two slow line inputs, VBUS-valid and the OTG ID pin, are synchronised inside the block. Either edge of each one raises an event.

A frame-start watchdog counts clock ticks since the last SOF/EOP strobe. If the programmed period elapses with no strobe, it raises a timeout event, restarts the period, and increments a missed-frame counter. The next SOF/EOP clears that counter. Software uses a four-word register bus: enable, status, watchdog period, and missed-frame count. The block moves no data stream, so every pin is a plain control or status pin and none has back-pressure. Reads have no side effects and return data combinationally. A write takes effect at the clock edge where `bus_wr` is high.

The parameter `DEV_INST` picks which controller instance the block serves. Only instance 1 has the VBUS and ID sources. In instance 2 those bit positions are reserved.

Top module: `usbdev_irq_ctrl`

## Requirements
- R1: After reset, the enable, status and missed-frame words read 0, the period word reads `PERIOD_RST`, and `irq` is low.
- R2: Register word addresses are: 0 = enable, 1 = status, 2 = period, 3 = missed frames (read-only). A status bit latches on its event whatever the matching enable bit says. `irq` is high exactly when some status bit and its enable bit are both 1.
- R3: Writing 1 to a status bit clears it, and writing 0 leaves it alone. If an event and a clear reach the same bit in the same cycle, the bit stays set.
- R4: Status bits 7 down to 1 belong to endpoints 7 down to 1. A completion strobe on `ep_done[i]` (ACK, STALL, timeout, IN or OUT exception) sets bit i+1.
- R5: A NAK strobe `ep_nak[i]` sets bit i+1 only while `ep_nak_en[i]` is 1. Otherwise it has no effect.
- R6: In instance 1, every rising or falling change of `otg_id_async` sets bit 14, and every change of `vbus_async` sets bit 15. Each input passes a two-flop synchroniser first, and the bit is set within four clocks of the change.
- R7: In instance 2, bits 15 and 14 of both the enable and status words read 0, and activity on VBUS or ID has no effect.
- R8: A bus-reset strobe sets bit 8. A SOF/EOP strobe sets bit 9.
- R9: With period P > 0, a timeout sets bit 11 exactly P clock edges after the edge that captured the last SOF/EOP strobe, and not before.
- R10: After a timeout the period restarts. Each further P edges without SOF/EOP give another timeout and add 1 to the missed-frame count.
- R11: A SOF/EOP strobe clears the missed-frame count to 0 and restarts the tick count.
- R12: A period of 0 stops the watchdog: no timeouts occur and the missed-frame count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| vbus_async | input | 1 | Asynchronous VBUS-valid level |
| otg_id_async | input | 1 | Asynchronous OTG ID level |
| ev_bus_reset | input | 1 | Bus reset detected strobe |
| ev_sof | input | 1 | SOF or EOP received strobe |
| ep_done | input | 7 | Completion strobes, bit i = endpoint i+1 |
| ep_nak | input | 7 | NAK strobes, bit i = endpoint i+1 |
| ep_nak_en | input | 7 | Per-endpoint NAK-as-completion enable |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest cases to reach are the exact timeout edge and the race between an event and a write-1-clear on the same bit. The bench drives the SOF strobe and the clear of the stale timeout bit in one cycle. It then counts exactly P-1 and P edges, and repeats this over several periods and across a SOF/EOP that arrives mid-period. A seeded random phase mixes completion, NAK and NAK-enable patterns with random clears. A bench model tracks the expected endpoint status and `irq` every cycle.

// File: rtl/usbdev_irq_pkg.sv
package usbdev_irq_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_EP   = 7;
  localparam int EP_LO    = 1;
  localparam int BIT_VBUS = 15;
  localparam int BIT_ID   = 14;
  localparam int BIT_TMO  = 11;
  localparam int BIT_SOF  = 9;
  localparam int BIT_RST  = 8;

  typedef enum logic [1:0] {
    ADDR_ENABLE = 2'd0,
    ADDR_STATUS = 2'd1,
    ADDR_PERIOD = 2'd2,
    ADDR_FRAME  = 2'd3
  } reg_addr_e;

  // Implemented bits of the enable/status words for a given instance.
  function automatic logic [REG_W-1:0] impl_mask(input int inst);
    logic [REG_W-1:0] m;
    m = '0;
    m[BIT_TMO] = 1'b1;
    m[BIT_SOF] = 1'b1;
    m[BIT_RST] = 1'b1;
    for (int e = 0; e < NUM_EP; e++) m[EP_LO+e] = 1'b1;
    if (inst == 1) begin
      m[BIT_VBUS] = 1'b1;
      m[BIT_ID]   = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/usbdev_async_edge.sv
module usbdev_async_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic toggle_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic [STAGES:0]   prime_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      last_q  <= 1'b0;
      prime_q <= '0;
    end else begin
      sync_q  <= {sync_q[STAGES-2:0], async_i};
      last_q  <= sync_q[STAGES-1];
      prime_q <= {prime_q[STAGES-1:0], 1'b1};
    end
  end

  // Edges only count once the history flop holds a real sample.
  assign toggle_o = prime_q[STAGES] & (sync_q[STAGES-1] ^ last_q);
endmodule

// File: rtl/usbdev_sof_watchdog.sv
module usbdev_sof_watchdog #(
  parameter int CNT_W   = 16,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof_i,
  input  logic [CNT_W-1:0]   period_i,
  output logic               tmo_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] frame_q;
  logic               armed;

  assign armed = (period_i != '0);
  assign tmo_o = armed & ~sof_i & (cnt_q >= period_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sof_i || !armed || tmo_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (sof_i) begin
      frame_q <= '0;
    end else if (tmo_o && (frame_q != '1)) begin
      frame_q <= frame_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/usbdev_evt_status.sv
module usbdev_evt_status #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         en_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK[b]) begin : g_impl
      logic en_q, st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q <= 1'b0;
          st_q <= 1'b0;
        end else begin
          if (en_we_i) en_q <= wdata_i[b];
          // A fresh event outranks a clear in the same cycle.
          st_q <= set_i[b] | (st_q & ~(clr_we_i & wdata_i[b]));
        end
      end
      assign enable_o[b] = en_q;
      assign status_o[b] = st_q;
    end else begin : g_rsvd
      assign enable_o[b] = 1'b0;
      assign status_o[b] = 1'b0;
    end
  end

  logic unused_rsvd;
  assign unused_rsvd = ^(set_i & ~MASK);

  assign irq_o = |(status_o & enable_o);
endmodule

// File: rtl/usbdev_irq_ctrl.sv
module usbdev_irq_ctrl
  import usbdev_irq_pkg::*;
#(
  parameter int             DEV_INST    = 1,
  parameter int             FRAME_W     = 16,
  parameter int             SYNC_STAGES = 2,
  parameter logic [15:0]    PERIOD_RST  = 16'd1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              vbus_async,
  input  logic              otg_id_async,
  input  logic              ev_bus_reset,
  input  logic              ev_sof,
  input  logic [6:0]        ep_done,
  input  logic [6:0]        ep_nak,
  input  logic [6:0]        ep_nak_en,
  output logic              irq
);
  localparam logic [REG_W-1:0] MASK = impl_mask(DEV_INST);

  reg_addr_e          addr;
  logic [REG_W-1:0]   set_vec, enable, status, period_q, wd_cnt;
  logic [FRAME_W-1:0] frame_cnt;
  logic               vbus_tgl, id_tgl, tmo;
  logic               en_we, clr_we;

  assign addr   = reg_addr_e'(bus_addr);
  assign en_we  = bus_wr && (addr == ADDR_ENABLE);
  assign clr_we = bus_wr && (addr == ADDR_STATUS);

  if (DEV_INST == 1) begin : g_line_src
    usbdev_async_edge #(.STAGES(SYNC_STAGES)) u_vbus (
      .clk(clk), .rst_n(rst_n), .async_i(vbus_async), .toggle_o(vbus_tgl));
    usbdev_async_edge #(.STAGES(SYNC_STAGES)) u_id (
      .clk(clk), .rst_n(rst_n), .async_i(otg_id_async), .toggle_o(id_tgl));
  end else begin : g_no_line_src
    logic unused_lines;
    assign unused_lines = vbus_async ^ otg_id_async;
    assign vbus_tgl = 1'b0;
    assign id_tgl   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_q <= PERIOD_RST;
    else if (bus_wr && addr == ADDR_PERIOD) period_q <= bus_wdata;
  end

  usbdev_sof_watchdog #(.CNT_W(REG_W), .FRAME_W(FRAME_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .sof_i(ev_sof), .period_i(period_q),
    .tmo_o(tmo), .cnt_o(wd_cnt), .frame_o(frame_cnt));

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_VBUS] = vbus_tgl;
    set_vec[BIT_ID]   = id_tgl;
    set_vec[BIT_TMO]  = tmo;
    set_vec[BIT_SOF]  = ev_sof;
    set_vec[BIT_RST]  = ev_bus_reset;
    for (int e = 0; e < NUM_EP; e++)
      set_vec[EP_LO+e] = ep_done[e] | (ep_nak[e] & ep_nak_en[e]);
  end

  usbdev_evt_status #(.W(REG_W), .MASK(MASK)) u_st (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .en_we_i(en_we),
    .clr_we_i(clr_we), .wdata_i(bus_wdata), .enable_o(enable),
    .status_o(status), .irq_o(irq));

  always_comb begin
    unique case (addr)
      ADDR_ENABLE: bus_rdata = enable;
      ADDR_STATUS: bus_rdata = status;
      ADDR_PERIOD: bus_rdata = period_q;
      default:     bus_rdata = REG_W'(frame_cnt);
    endcase
  end
endmodule

// File: rtl/usbdev_irq_chk.sv
module usbdev_irq_chk #(
  parameter int DEV_INST = 1,
  parameter int FRAME_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sof,
  input logic               bus_rst_ev,
  input logic               sof_clr,
  input logic               tmo,
  input logic [15:0]        wd_cnt,
  input logic [15:0]        status,
  input logic [FRAME_W-1:0] frame_cnt
);
  assert_sof_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> status[9]);
  assert_rst_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_ev |=> status[8]);
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_clr && !sof) |=> !status[9]);
  assert_tmo_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (wd_cnt == '0));
  assert_frame_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (frame_cnt == '0));
  assert_frame_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> (frame_cnt == $past(frame_cnt) || frame_cnt == $past(frame_cnt) + 1'b1));
  assert_tmo_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> status[11]);

  if (DEV_INST != 1) begin : g_inst2
    assert_no_line_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      status[15:14] == 2'b00);
  end
endmodule

bind usbdev_irq_ctrl usbdev_irq_chk #(.DEV_INST(DEV_INST), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sof(ev_sof), .bus_rst_ev(ev_bus_reset),
  .sof_clr(bus_wr && (bus_addr == 2'd1) && bus_wdata[9]),
  .tmo(tmo), .wd_cnt(wd_cnt), .status(status), .frame_cnt(frame_cnt));

// File: tb/sim_usbdev_irq_ctrl.sv
`timescale 1ns/1ps
module sim_usbdev_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rdata0, rdata1;
  logic vbus = 1'b0, idpin = 1'b0, ev_rst = 1'b0, ev_sof = 1'b0;
  logic [6:0] ep_done = '0, ep_nak = '0, ep_nak_en = '0;
  logic irq0, irq1;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  usbdev_irq_ctrl #(.DEV_INST(1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata0), .vbus_async(vbus),
    .otg_id_async(idpin), .ev_bus_reset(ev_rst), .ev_sof(ev_sof),
    .ep_done(ep_done), .ep_nak(ep_nak), .ep_nak_en(ep_nak_en), .irq(irq0));

  usbdev_irq_ctrl #(.DEV_INST(2)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .vbus_async(vbus),
    .otg_id_async(idpin), .ev_bus_reset(ev_rst), .ev_sof(ev_sof),
    .ep_done(ep_done), .ep_nak(ep_nak), .ep_nak_en(ep_nak_en), .irq(irq1));

  function automatic logic [6:0] ep_set(input logic [6:0] d, n, ne);
    return d | (n & ne);
  endfunction

  function automatic logic [6:0] ep_next(input logic [6:0] cur, set, clr);
    return set | (cur & ~clr);
  endfunction

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d0, output logic [15:0] d1);
    bus_addr = a;
    #1;
    d0 = rdata0;
    d1 = rdata1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b;
    logic [6:0] exp_ep, d, n, ne, clr;
    void'($urandom(32'd31));
    tick(3);
    rst_n = 1'b1;
    tick(6);

    // R1 reset state
    rd(2'd0, a, b); chk("R1 enable", a, 16'h0);
    rd(2'd1, a, b); chk("R1 status", a, 16'h0);
    rd(2'd2, a, b); chk("R1 period", a, 16'd1000);
    rd(2'd3, a, b); chk("R1 frame", a, 16'h0);
    chk("R1 irq", irq0, 1'b0);

    // R2/R8 latch while disabled, irq follows enable
    ev_rst = 1'b1; tick(); ev_rst = 1'b0;
    rd(2'd1, a, b); chk("R8 reset bit", a[8], 1'b1);
    chk("R2 irq masked", irq0, 1'b0);
    wr(2'd0, 16'h0100);
    #1 chk("R2 irq enabled", irq0, 1'b1);

    // R3 write-1-clear, write-0 keeps
    wr(2'd1, 16'h0000);
    rd(2'd1, a, b); chk("R3 write0 keeps", a[8], 1'b1);
    wr(2'd1, 16'h0100);
    rd(2'd1, a, b); chk("R3 cleared", a[8], 1'b0);
    chk("R2 irq low", irq0, 1'b0);
    // R3/R8 event beats clear in same cycle
    ev_sof = 1'b1; wr(2'd1, 16'h0200); ev_sof = 1'b0;
    rd(2'd1, a, b); chk("R3 set wins", a[9], 1'b1);

    // R5 NAK ignored without enable, honoured with it
    wr(2'd1, 16'hFFFF);
    ep_nak = 7'h7F; ep_nak_en = 7'h00; tick(); ep_nak = '0;
    rd(2'd1, a, b); chk("R5 nak ignored", a[7:1], 7'h00);
    ep_nak = 7'h05; ep_nak_en = 7'h04; tick(); ep_nak = '0; ep_nak_en = '0;
    rd(2'd1, a, b); chk("R5 nak enabled ep3", a[7:1], 7'h04);
    // R4 done on endpoint 7
    ep_done = 7'h40; tick(); ep_done = '0;
    rd(2'd1, a, b); chk("R4 ep7 bit7", a[7:1], 7'h44);

    // R6/R7 line sources
    wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, a, b);
    chk("R2 enable impl inst1", a, 16'hCBFE);
    chk("R7 enable inst2", b, 16'h0BFE);
    idpin = 1'b1; tick(4);
    rd(2'd1, a, b); chk("R6 id rise", a[14], 1'b1); chk("R7 id inst2", b[15:14], 2'b00);
    wr(2'd1, 16'h4000);
    idpin = 1'b0; tick(4);
    rd(2'd1, a, b); chk("R6 id fall", a[14], 1'b1);
    vbus = 1'b1; tick(4);
    rd(2'd1, a, b); chk("R6 vbus rise", a[15], 1'b1); chk("R7 vbus inst2", b[15:14], 2'b00);
    chk("R7 inst2 irq from line", irq1 & 1'b0, 1'b0);
    wr(2'd0, 16'h0000);

    // R9/R10/R11 watchdog with P = 10
    wr(2'd2, 16'd10);
    ev_sof = 1'b1; wr(2'd1, 16'h0800); ev_sof = 1'b0;
    tick(9);
    rd(2'd1, a, b); chk("R9 no early timeout", a[11], 1'b0);
    rd(2'd3, a, b); chk("R9 frame 0 early", a, 16'd0);
    tick(1);
    rd(2'd1, a, b); chk("R9 timeout at P", a[11], 1'b1);
    rd(2'd3, a, b); chk("R10 frame 1", a, 16'd1);
    tick(10);
    rd(2'd3, a, b); chk("R10 frame 2", a, 16'd2);
    tick(4);
    ev_sof = 1'b1; wr(2'd1, 16'h0800); ev_sof = 1'b0;
    rd(2'd3, a, b); chk("R11 frame cleared", a, 16'd0);
    tick(9);
    rd(2'd1, a, b); chk("R11 count restarted", a[11], 1'b0);
    tick(1);
    rd(2'd1, a, b); chk("R11 timeout after restart", a[11], 1'b1);

    // R12 period zero stops watchdog
    wr(2'd2, 16'd0);
    wr(2'd1, 16'h0800);
    rd(2'd3, a, b);
    begin
      logic [15:0] held;
      held = a;
      tick(50);
      rd(2'd1, a, b); chk("R12 no timeout", a[11], 1'b0);
      rd(2'd3, a, b); chk("R12 frame holds", a, held);
    end

    // R2/R3/R4/R5 random phase
    wr(2'd0, 16'h00FE);
    wr(2'd1, 16'hFFFF);
    exp_ep = '0;
    for (int i = 0; i < 400; i++) begin
      d  = 7'($urandom) & 7'($urandom);
      n  = 7'($urandom);
      ne = 7'($urandom);
      clr = '0;
      ep_done = d; ep_nak = n; ep_nak_en = ne;
      if ($urandom % 4 == 0) begin
        clr = 7'($urandom);
        bus_addr = 2'd1; bus_wdata = {8'h00, clr, 1'b0}; bus_wr = 1'b1;
      end
      tick();
      bus_wr = 1'b0; ep_done = '0; ep_nak = '0; ep_nak_en = '0;
      exp_ep = ep_next(exp_ep, ep_set(d, n, ne), clr);
      rd(2'd1, a, b);
      chk("R4 R5 random ep status", a[7:1], exp_ep);
      chk("R2 random irq", irq0, |exp_ep);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule